// File: doc/BRIEF.md
# Received Pause Frame Transmit Inhibitor

This block sits behind the receive parser of an Ethernet MAC. Once per parsed frame, the parser raises a one-cycle strobe and presents four fields: destination address, type/length, control opcode and pause time. The block decides whether the frame is a flow-control pause request. If it is, the block loads a countdown with the requested number of pause quanta and holds the local transmitter off until the countdown reaches zero.

A pause request is accepted when it is sent to the reserved multicast address for pause frames. When unicast detection is enabled, a request sent to the station's own configured address is also accepted. A strobe that pulses once per bit time drives a slot prescaler. Each quantum lasts one slot time, which is 512 bit times by default. When receive flow control is switched off, the block decodes nothing and keeps the inhibit low.

Top module: `pause_rx_inhibit`

## Requirements
- R1: While `rx_fc_en` is low, no frame is decoded. One clock after `rx_fc_en` is sampled low, `pause_remaining` is 0 and `tx_inhibit` is low, including when a pause was running.
- R2: A qualifying frame strobe with `rx_fc_en` high loads `rx_pause_time` into `pause_remaining`. The new value is visible one clock after the strobe.
- R3: With `ucast_detect_en` low, only destination 48'h0180C2000001 qualifies. Octet 01 is the first on the wire and sits in bits [47:40]. A frame to the station address is ignored.
- R4: With `ucast_detect_en` high, a frame whose destination equals `station_addr` also qualifies.
- R5: A frame qualifies only if `rx_type` is 16'h8808 and `rx_opcode` is 16'h0001. Any other value leaves the count unchanged.
- R6: `pause_remaining` decrements by one every BITS_PER_SLOT strobes of `bit_tick` (default 512). A load restarts the slot prescaler, so the first decrement follows the BITS_PER_SLOT-th strobe after the load.
- R7: `tx_inhibit` is high exactly while `pause_remaining` is non-zero. A pause of P reaches zero after P slot times.
- R8: A qualifying frame that arrives during a pause reloads the count with its own pause time.
- R9: A qualifying frame with pause time 0 clears the count one clock after the strobe, which ends the inhibit at once.
- R10: Without `bit_tick` strobes, the count holds its value.
- R11: After reset, `pause_remaining` is 0 and `tx_inhibit` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_valid | input | 1 | One-cycle strobe: parsed fields are valid |
| rx_dst_addr | input | 48 | Destination address, first octet in [47:40] |
| rx_type | input | 16 | Type/length field |
| rx_opcode | input | 16 | MAC control opcode |
| rx_pause_time | input | 16 | Requested pause in quanta |
| station_addr | input | 48 | Station's own primary address |
| rx_fc_en | input | 1 | Receive flow control enable |
| ucast_detect_en | input | 1 | Also accept pause frames to `station_addr` |
| bit_tick | input | 1 | One pulse per bit time |
| tx_inhibit | output | 1 | Transmitter hold-off level |
| pause_remaining | output | 16 | Slot times of pause left |

## Verification
The bench builds the block with BITS_PER_SLOT set to 4 and keeps QUANTA_W at 16. This makes a slot last four clocks when `bit_tick` is held high. Every countdown, including a reload in the middle of a slot and a restart after a stretch without bit strobes, then completes within a few dozen cycles. The exact cycle of each decrement can therefore be predicted and checked, along with the effect of the prescaler restart on a reload.

// File: rtl/pause_pkg.sv
package pause_pkg;
  localparam int MAC_W = 48;
  localparam logic [MAC_W-1:0] PAUSE_MCAST_DA = 48'h0180C2000001;
  localparam logic [15:0]      MAC_CTRL_TYPE  = 16'h8808;
  localparam logic [15:0]      PAUSE_OPCODE   = 16'h0001;
endpackage

// File: rtl/pause_frame_match.sv
module pause_frame_match
  import pause_pkg::*;
(
  input  logic             frame_valid,
  input  logic [MAC_W-1:0] dst_addr,
  input  logic [15:0]      type_fld,
  input  logic [15:0]      opcode_fld,
  input  logic [MAC_W-1:0] own_addr,
  input  logic             fc_en,
  input  logic             ucast_en,
  output logic             pause_hit
);
  logic mcast_da;
  logic own_da;
  logic ctrl_ok;

  always_comb begin
    mcast_da  = (dst_addr == PAUSE_MCAST_DA);
    own_da    = ucast_en && (dst_addr == own_addr);
    ctrl_ok   = (type_fld == MAC_CTRL_TYPE) && (opcode_fld == PAUSE_OPCODE);
    pause_hit = frame_valid && fc_en && ctrl_ok && (mcast_da || own_da);
  end
endmodule

// File: rtl/slot_prescaler.sv
module slot_prescaler #(
  parameter int BITS_PER_SLOT = 512
) (
  input  logic clk,
  input  logic rst_n,
  input  logic restart,
  input  logic bit_tick,
  output logic slot_tick
);
  localparam int PW = (BITS_PER_SLOT > 1) ? $clog2(BITS_PER_SLOT) : 1;
  localparam logic [PW-1:0] LAST = PW'(BITS_PER_SLOT - 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] pre_d;
  logic          pre_en;
  logic          wrap;

  always_comb begin
    wrap      = (pre_q == LAST);
    slot_tick = bit_tick && !restart && wrap;
    pre_en    = restart || bit_tick;
    if (restart)   pre_d = '0;
    else if (wrap) pre_d = '0;
    else           pre_d = pre_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      pre_q <= '0;
    else if (pre_en) pre_q <= pre_d;
  end

  AST_PRESCALER_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    pre_q <= LAST); // R6
endmodule

// File: rtl/pause_countdown.sv
module pause_countdown #(
  parameter int QUANTA_W = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fc_en,
  input  logic                load,
  input  logic [QUANTA_W-1:0] load_val,
  input  logic                slot_tick,
  output logic [QUANTA_W-1:0] remaining
);
  logic [QUANTA_W-1:0] cnt_q;
  logic [QUANTA_W-1:0] cnt_d;
  logic                cnt_en;

  always_comb begin
    cnt_en = !fc_en || load || slot_tick;
    if (!fc_en)                       cnt_d = '0;
    else if (load)                    cnt_d = load_val;
    else if (slot_tick && cnt_q != 0) cnt_d = cnt_q - 1'b1;
    else                              cnt_d = cnt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= cnt_d;
  end

  assign remaining = cnt_q;

  AST_OFF_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    !fc_en |=> cnt_q == '0); // R1
  AST_LOAD_VALUE: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_en && load) |=> cnt_q == $past(load_val)); // R2
  AST_STEP_DOWN_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_en && !load) |=> (cnt_q == $past(cnt_q)) || (cnt_q == $past(cnt_q) - 1'b1)); // R7
  AST_HOLD_NO_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    (fc_en && !load && !slot_tick) |=> $stable(cnt_q)); // R10
endmodule

// File: rtl/pause_rx_inhibit.sv
module pause_rx_inhibit
  import pause_pkg::*;
#(
  parameter int BITS_PER_SLOT = 512,
  parameter int QUANTA_W      = 16
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_valid,
  input  logic [47:0]         rx_dst_addr,
  input  logic [15:0]         rx_type,
  input  logic [15:0]         rx_opcode,
  input  logic [QUANTA_W-1:0] rx_pause_time,
  input  logic [47:0]         station_addr,
  input  logic                rx_fc_en,
  input  logic                ucast_detect_en,
  input  logic                bit_tick,
  output logic                tx_inhibit,
  output logic [QUANTA_W-1:0] pause_remaining
);
  logic hit;
  logic slot_tick;
  logic pre_restart;

  pause_frame_match u_match (
    .frame_valid (frame_valid),
    .dst_addr    (rx_dst_addr),
    .type_fld    (rx_type),
    .opcode_fld  (rx_opcode),
    .own_addr    (station_addr),
    .fc_en       (rx_fc_en),
    .ucast_en    (ucast_detect_en),
    .pause_hit   (hit)
  );

  assign pre_restart = hit || !rx_fc_en;

  slot_prescaler #(.BITS_PER_SLOT(BITS_PER_SLOT)) u_pre (
    .clk       (clk),
    .rst_n     (rst_n),
    .restart   (pre_restart),
    .bit_tick  (bit_tick),
    .slot_tick (slot_tick)
  );

  pause_countdown #(.QUANTA_W(QUANTA_W)) u_cnt (
    .clk       (clk),
    .rst_n     (rst_n),
    .fc_en     (rx_fc_en),
    .load      (hit),
    .load_val  (rx_pause_time),
    .slot_tick (slot_tick),
    .remaining (pause_remaining)
  );

  assign tx_inhibit = (pause_remaining != '0);

  AST_UCAST_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && !ucast_detect_en && rx_dst_addr != PAUSE_MCAST_DA && pause_remaining == '0)
    |=> pause_remaining == '0); // R3
  AST_BAD_OPCODE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (frame_valid && rx_opcode != PAUSE_OPCODE && pause_remaining == '0)
    |=> pause_remaining == '0); // R5
endmodule

// File: tb/tb_pause_rx_inhibit.sv
module tb_pause_rx_inhibit;
  localparam int CLK_PERIOD = 10;
  localparam int SLOT = 4;
  localparam logic [47:0] MC  = 48'h0180C2000001;
  localparam logic [47:0] OWN = 48'h02AABBCCDDEE;

  logic        clk = 0;
  logic        rst_n;
  logic        frame_valid;
  logic [47:0] rx_dst_addr;
  logic [15:0] rx_type, rx_opcode, rx_pause_time;
  logic        rx_fc_en, ucast_detect_en, bit_tick;
  logic        tx_inhibit;
  logic [15:0] pause_remaining;

  int tests = 0, fails = 0, cyc = 0;
  int          qc[$];
  logic [15:0] qv[$];
  string       qt[$];

  always #(CLK_PERIOD/2) clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pause_rx_inhibit #(.BITS_PER_SLOT(SLOT), .QUANTA_W(16)) dut (
    .clk(clk), .rst_n(rst_n), .frame_valid(frame_valid), .rx_dst_addr(rx_dst_addr),
    .rx_type(rx_type), .rx_opcode(rx_opcode), .rx_pause_time(rx_pause_time),
    .station_addr(OWN), .rx_fc_en(rx_fc_en), .ucast_detect_en(ucast_detect_en),
    .bit_tick(bit_tick), .tx_inhibit(tx_inhibit), .pause_remaining(pause_remaining));

  task automatic expect_at(input int c, input logic [15:0] v, input string t);
    qc.push_back(c); qv.push_back(v); qt.push_back(t);
  endtask

  // monitor: pops expectations due this cycle and compares
  always @(negedge clk) begin
    while (qc.size() > 0 && qc[0] <= cyc) begin
      tests++;
      if (qc[0] < cyc) begin
        fails++;
        $display("FAIL %s: stale expectation at cycle %0d (actual %0d expected %0d)", qt[0], cyc, pause_remaining, qv[0]);
      end else if (pause_remaining !== qv[0] || tx_inhibit !== (qv[0] != 0)) begin
        fails++;
        $display("FAIL %s: cycle %0d actual remaining=%0d inhibit=%0b expected remaining=%0d inhibit=%0b",
                 qt[0], cyc, pause_remaining, tx_inhibit, qv[0], qv[0] != 0);
      end
      void'(qc.pop_front()); void'(qv.pop_front()); void'(qt.pop_front());
    end
  end

  task automatic send(input logic [47:0] da, input logic [15:0] ty, input logic [15:0] op, input logic [15:0] pt);
    rx_dst_addr = da; rx_type = ty; rx_opcode = op; rx_pause_time = pt; frame_valid = 1;
    @(negedge clk);
    frame_valid = 0;
  endtask

  task automatic wait_until(input int c);
    while (cyc < c) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    tests++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int k;
    rst_n = 0; frame_valid = 0; rx_dst_addr = 0; rx_type = 0; rx_opcode = 0;
    rx_pause_time = 0; rx_fc_en = 1; ucast_detect_en = 0; bit_tick = 1;
    repeat (3) @(negedge clk);
    rst_n = 1;
    k = cyc; expect_at(k + 1, 0, "R11 reset state");
    repeat (3) @(negedge clk);

    // R2 R6 R7: multicast pause of 3 counts down one per 4 strobes
    k = cyc;
    expect_at(k + 1, 3, "R2 load");
    expect_at(k + 4, 3, "R6 before first slot");
    expect_at(k + 5, 2, "R6 first decrement");
    expect_at(k + 9, 1, "R7 second slot");
    expect_at(k + 13, 0, "R7 reaches zero");
    send(MC, 16'h8808, 16'h0001, 16'd3);
    wait_until(k + 16);

    // R3: station address ignored when unicast detect off
    k = cyc;
    expect_at(k + 1, 0, "R3 unicast ignored");
    send(OWN, 16'h8808, 16'h0001, 16'd7);
    wait_until(k + 3);

    // R4: station address accepted when unicast detect on
    ucast_detect_en = 1;
    k = cyc;
    expect_at(k + 1, 7, "R4 unicast accepted");
    send(OWN, 16'h8808, 16'h0001, 16'd7);
    wait_until(k + 2);
    rx_fc_en = 0;           // R1: disable during running pause
    k = cyc;
    expect_at(k + 1, 0, "R1 disable clears pause");
    wait_until(k + 3);

    // R1: no decode while disabled
    k = cyc;
    expect_at(k + 1, 0, "R1 frame ignored when disabled");
    expect_at(k + 5, 0, "R1 stays off");
    send(MC, 16'h8808, 16'h0001, 16'd9);
    wait_until(k + 6);
    rx_fc_en = 1; ucast_detect_en = 0;
    @(negedge clk);

    // R5: wrong type, wrong opcode
    k = cyc;
    expect_at(k + 1, 0, "R5 wrong type ignored");
    send(MC, 16'h0800, 16'h0001, 16'd5);
    k = cyc;
    expect_at(k + 1, 0, "R5 wrong opcode ignored");
    send(MC, 16'h8808, 16'h0002, 16'd5);
    @(negedge clk);

    // R8: reload mid pause restarts the slot prescaler
    k = cyc;
    expect_at(k + 1, 5, "R8 first load");
    expect_at(k + 5, 4, "R8 first decrement");
    send(MC, 16'h8808, 16'h0001, 16'd5);
    wait_until(k + 6);
    k = cyc;
    expect_at(k + 1, 2, "R8 reload value");
    expect_at(k + 4, 2, "R8 prescaler restarted");
    expect_at(k + 5, 1, "R8 decrement after reload");
    expect_at(k + 9, 0, "R8 ends");
    send(MC, 16'h8808, 16'h0001, 16'd2);
    wait_until(k + 11);

    // R9: zero pause ends inhibit immediately
    k = cyc;
    expect_at(k + 1, 6, "R9 load before zero");
    send(MC, 16'h8808, 16'h0001, 16'd6);
    wait_until(k + 3);
    k = cyc;
    expect_at(k + 1, 0, "R9 zero pause clears");
    send(MC, 16'h8808, 16'h0001, 16'd0);
    @(negedge clk);

    // R10: no bit strobes, count holds; resumes afterwards (R6)
    bit_tick = 0;
    k = cyc;
    expect_at(k + 1, 2, "R10 load with no strobes");
    expect_at(k + 20, 2, "R10 held");
    send(MC, 16'h8808, 16'h0001, 16'd2);
    wait_until(k + 20);
    bit_tick = 1;
    expect_at(k + 24, 1, "R6 resumed decrement");
    expect_at(k + 28, 0, "R7 ends after resume");
    wait_until(k + 32);

    if (qc.size() != 0) begin
      tests++; fails++;
      $display("FAIL drain: actual %0d pending expected 0", qc.size());
    end
    finish_run();
  end
endmodule